// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block is the control logic for a four-channel converter front end. It decides which channels take part in a conversion sequence. It then requests one conversion per chosen channel, always lowest channel first, and reports when the sequence is complete.

The channel-enable mask comes from one of two sources, chosen by a mode input. The first source is four hardware select pins. The second is a 4-bit select register, written from the low four bits of the data bus under active-low chip-select, write and read strobes.

When a rising edge of the conversion start input is detected, the mask is captured and held until the sequence ends. The analog sampling and the result path are outside this block. A done strobe from the converter core moves the sequencer from one channel to the next.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `hw_mode` high the mask is taken from `sel_pins`. With `hw_mode` low it is taken from the select register. Mask bit i enables channel index i, so bit 0 is `chan_idx` 0 and bit 3 is `chan_idx` 3.
- R2: Each set bit of the captured mask produces exactly one `conv_req` pulse. The pulses come in strictly ascending `chan_idx` order, and no request is made for a clear bit.
- R3: The mask is sampled in the clock cycle where a 0-to-1 change of `convst` is detected. Changes to `sel_pins` or to the register after that point do not alter the running sequence.
- R4: The register loads bits 3:0 of `bus_lo`, as held while `wr_n` was low, on a low-to-high change of `wr_n`. The load happens only if `cs_n` was low and `rd_n` was high in the cycle before. A write with `cs_n` high or with `rd_n` low leaves the register unchanged.
- R5: The register keeps its value across any number of sequences until it is written again.
- R6: With `hw_mode` low, `sel_pins` have no effect on the sequence.
- R7: An all-zero captured mask ends the sequence with no `conv_req`. In that case `seq_end` is asserted two cycles after `convst` is first sampled high.
- R8: A `convst` rising edge that arrives while `busy` is high is ignored.
- R9: After a request the sequencer waits for `conv_done`. The next request follows one cycle after the `conv_done` cycle. A `conv_done` pulse while idle has no effect.
- R10: `busy` rises one cycle after `convst` is first sampled high and stays high until the sequence ends. `conv_req` and `seq_end` are single-cycle pulses. `seq_end` is high in the first cycle in which `busy` is low again, one cycle after the last `conv_done`.
- R11: After reset, `busy`, `conv_req`, `seq_end` and `chan_idx` are 0 and the select register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1: mask from pins, 0: mask from register |
| sel_pins | input | 4 | Hardware channel select pins |
| bus_lo | input | 4 | Low data-bus bits carrying register writes |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| convst | input | 1 | Conversion start; rising edge starts a sequence |
| conv_done | input | 1 | Converter core finished the requested channel |
| chan_idx | output | 2 | Channel of the current request |
| conv_req | output | 1 | One-cycle convert request |
| busy | output | 1 | High while a sequence runs |
| seq_end | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume that every strobe is synchronous to the clock and lasts at least one cycle. They also assume that `wr_n` returns high before `cs_n` is released. The stimulus changes inputs only shortly after a rising edge and holds each level for whole cycles. Register writes last exactly two cycles with chip select held low throughout. The bench sweeps every mask value in both modes. In doing so it puts the complement of the mask on the unused source, and it injects start pulses, pin changes and register writes while sequences are running.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_mode,
  input  logic [NCH-1:0] sel_pins,
  input  logic [NCH-1:0] bus_lo,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          convst,
  input  logic          conv_done,
  output logic [IW-1:0] chan_idx,
  output logic          conv_req,
  output logic          busy,
  output logic          seq_end
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT} state_t;
  state_t state;

  logic           wr_q, cs_q, rd_q, cv_q;
  logic [NCH-1:0] bus_q, csr, rem;
  logic [NCH-1:0] live_mask;
  logic [IW-1:0]  low_idx;
  logic           start, wr_commit;

  assign live_mask = hw_mode ? sel_pins : csr;
  assign start     = convst && !cv_q;
  assign wr_commit = wr_n && !wr_q && !cs_q && rd_q;
  assign busy      = (state != S_IDLE);

  always_comb begin
    low_idx = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (rem[i]) low_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      cs_q  <= 1'b1;
      rd_q  <= 1'b1;
      cv_q  <= 1'b0;
      bus_q <= '0;
      csr   <= '0;
    end else begin
      wr_q  <= wr_n;
      cs_q  <= cs_n;
      rd_q  <= rd_n;
      cv_q  <= convst;
      bus_q <= bus_lo;
      if (wr_commit) csr <= bus_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rem      <= '0;
      chan_idx <= '0;
      conv_req <= 1'b0;
      seq_end  <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      seq_end  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          rem   <= live_mask;
          state <= S_SCAN;
        end
        S_SCAN: if (rem == '0) begin
          seq_end <= 1'b1;
          state   <= S_IDLE;
        end else begin
          chan_idx     <= low_idx;
          conv_req     <= 1'b1;
          rem[low_idx] <= 1'b0;
          state        <= S_WAIT;
        end
        S_WAIT: if (conv_done) state <= S_SCAN;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [NCH-1:0] cap_mask;
  logic [IW-1:0]  last_idx;
  logic           any_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_mask <= '0;
      last_idx <= '0;
      any_req  <= 1'b0;
    end else if (start && !busy) begin
      cap_mask <= live_mask;
      any_req  <= 1'b0;
    end else if (conv_req) begin
      last_idx <= chan_idx;
      any_req  <= 1'b1;
    end
  end

  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && any_req) |-> (chan_idx > last_idx));
  p_req_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> cap_mask[chan_idx]);
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |-> !busy);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy);
  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !conv_req);

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  logic       clk = 0, rst_n = 0;
  logic       hw_mode = 0, cs_n = 1, wr_n = 1, rd_n = 1, convst = 0, conv_done = 0;
  logic [3:0] sel_pins = 0, bus_lo = 0;
  logic [1:0] chan_idx;
  logic       conv_req, busy, seq_end;
  int total = 0, bad = 0, cyc = 0;

  adc_seq_ctrl uut (.clk, .rst_n, .hw_mode, .sel_pins, .bus_lo, .cs_n, .wr_n, .rd_n,
                    .convst, .conv_done, .chan_idx, .conv_req, .busy, .seq_end);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] d, input bit csv, input bit rdv);
    cs_n = csv; rd_n = rdv; wr_n = 0; bus_lo = d; step();
    wr_n = 1; step();
    cs_n = 1; rd_n = 1; bus_lo = ~d;
  endtask

  // mischief: start pulse and flip of pins during first wait
  task automatic run_seq(input logic [3:0] m, input int lat, input bit mis, input string tag);
    bit first = 1;
    convst = 1; step();
    chk(busy === 1'b1, {"R10 busy ", tag}, busy, 1);
    convst = 0;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        step();
        chk(conv_req === 1'b1 && chan_idx == 2'(i), {"R2 req ", tag},
            {conv_req, chan_idx}, 4 + i);
        for (int w = 0; w < lat; w++) begin
          if (mis && first && w == 0) begin convst = 1; sel_pins = ~sel_pins; end
          step();
          convst = 0;
          chk(conv_req === 1'b0 && busy === 1'b1, {"R9 wait ", tag}, {conv_req, busy}, 1);
        end
        first = 0;
        conv_done = 1; step(); conv_done = 0;
      end
    end
    step();
    chk(seq_end === 1'b1 && busy === 1'b0 && conv_req === 1'b0, {"R7 R10 end ", tag},
        {seq_end, busy, conv_req}, 4);
    step();
    chk(seq_end === 1'b0 && busy === 1'b0, {"R10 end pulse ", tag}, {seq_end, busy}, 0);
  endtask

  initial begin
    step(); step();
    chk(busy === 0 && conv_req === 0 && seq_end === 0 && chan_idx === 0, "R11 reset",
        {busy, conv_req, seq_end, chan_idx}, 0);
    rst_n = 1; step();
    hw_mode = 0; sel_pins = 4'hF;
    run_seq(4'h0, 2, 0, "R11 reg cleared");
    conv_done = 1; step(); conv_done = 0;
    chk(conv_req === 0 && busy === 0, "R9 idle done", {conv_req, busy}, 0);
    step();
    chk(conv_req === 0 && busy === 0, "R9 idle done later", {conv_req, busy}, 0);

    for (int md = 0; md < 2; md++) begin
      for (int m = 0; m < 16; m++) begin
        hw_mode = md[0];
        if (md == 0) begin write_reg(4'(m), 0, 1); sel_pins = ~4'(m); end
        else begin write_reg(~4'(m), 0, 1); sel_pins = 4'(m); end
        step();
        run_seq(4'(m), 1 + (m % 3), m[0], md == 0 ? "R1 R6 reg" : "R1 pins R3");
      end
    end

    hw_mode = 0;
    write_reg(4'b0101, 0, 1);
    write_reg(4'b1111, 1, 1);
    run_seq(4'b0101, 1, 0, "R4 cs high ignored");
    write_reg(4'b1111, 0, 0);
    run_seq(4'b0101, 1, 0, "R4 rd low ignored");
    run_seq(4'b0101, 2, 1, "R5 hold");

    convst = 1; step(); convst = 0;
    step();
    chk(conv_req && chan_idx == 0, "R3 first", chan_idx, 0);
    write_reg(4'b1010, 0, 1);
    conv_done = 1; step(); conv_done = 0;
    step();
    chk(conv_req && chan_idx == 2, "R3 frozen mask", chan_idx, 2);
    conv_done = 1; step(); conv_done = 0;
    step();
    chk(seq_end && !busy, "R3 end", seq_end, 1);
    step();
    run_seq(4'b1010, 1, 0, "R4 R5 new reg");

    hw_mode = 1; sel_pins = 4'b1001;
    convst = 1; step();
    sel_pins = 4'b0110; convst = 0; step();
    chk(conv_req && chan_idx == 0, "R3 pins latched", chan_idx, 0);
    conv_done = 1; step(); conv_done = 0; step();
    chk(conv_req && chan_idx == 3, "R3 pins latched 2", chan_idx, 3);
    conv_done = 1; step(); conv_done = 0; step();
    chk(seq_end && !busy, "R8 R10 finish", seq_end, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule